// File: doc/BRIEF.md
# Light-Sensor Integration Timing Controller

This block paces the conversion periods of an integrating light-sensor front end and captures each finished measurement. It has two timing modes. In the internal mode a cycle counter runs for a programmable number of ticks. In the external mode the host frames each measurement with sync strobes. In both modes a tick enable paces the counting. The tick enable fires on every clock in the two upper ranges and on every second clock in the two lower ranges.

In the external mode one measurement spans three sync strobes. The first strobe starts integration on photodiode array one. The second strobe moves integration to array two. The third strobe closes the measurement, publishes it and starts array one again. A 16-bit tick timer runs across both halves of the measurement and saturates instead of wrapping. At each publish the block latches the converter's signed result and the timer value into data registers, which the surrounding bus logic reads. The analog converter is modelled by the `adc_value` input.

Top module: `lsi_timing_ctrl`

## Requirements
- R1: While reset is held, and after it is released, `result_valid`, `sensor_data`, `timer_data`, `timer_sat` and `arr_phase` are all zero.
- R2: In the internal mode (`cmd_ext_mode`=0), `cmd_width` sets the number of ticks per conversion: 2'b00 gives 65536, 2'b01 gives 4096, 2'b10 gives 256 and 2'b11 gives 16. After the last tick's clock edge, `sensor_data` holds the `adc_value` sampled at that edge, and `result_valid` is high for exactly one cycle. Conversions then repeat back to back.
- R3: When `range_sel` is 2'b10 or 2'b11, a tick occurs on every enabled clock edge. When it is 2'b00 or 2'b01, a tick occurs on every second edge, and the first tick falls on the second edge after counting starts.
- R4: A result published in the internal mode sets `timer_data` to zero.
- R5: In the external mode, `arr_phase` reports the active array: 0 means idle, 1 means array one and 2 means array two. A sync strobe moves the phase from 0 to 1, from 1 to 2, and from 2 back to 1. The move from 2 to 1 publishes `adc_value` and sets `timer_data` to the number of ticks from the strobe that started the measurement up to, but not including, the closing strobe's edge.
- R6: The external-mode timer stops at 16'hFFFF. On the next tick after it reaches that value, `timer_sat` goes high and stays high until a strobe starts a new measurement.
- R7: While `cmd_enable`=0 or `cmd_pdown`=1, no tick is counted, sync strobes are ignored, `arr_phase` returns to 0 and the data registers keep their values. When operation resumes, counting starts again from zero.
- R8: A change of `cmd_width` or `cmd_ext_mode` while the block is running aborts the current integration. The change takes effect at the next clock edge, and counting starts again from zero on the tick after that edge.
- R9: In the internal mode, sync strobes have no effect: `arr_phase` stays 0 and the result timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_enable | input | 1 | 1 runs the converter sequencing; 0 holds it in reset |
| cmd_pdown | input | 1 | 1 halts conversion |
| cmd_ext_mode | input | 1 | 0 selects internal timing; 1 selects host-framed timing |
| cmd_width | input | 2 | Internal conversion length select |
| range_sel | input | 2 | Range select; the two lower ranges halve the tick rate |
| sync_stb | input | 1 | Host sync strobe, one clock wide |
| adc_value | input | 16 | Modelled signed converter result |
| result_valid | output | 1 | One-cycle pulse when new data has been latched |
| sensor_data | output | 16 | Latched signed sensor result |
| timer_data | output | 16 | Latched tick count for the last measurement |
| timer_sat | output | 1 | External timer reached its ceiling |
| arr_phase | output | 2 | Active photodiode array (0 idle, 1 first, 2 second) |

## Verification
Every result is due one register stage after the edge that closes the integration. For an internal conversion started at cycle c, that edge is c+N in the fast ranges and c+2N in the slow ranges. For an external measurement it is the edge that samples the third strobe. `timer_sat` rises one edge after tick 65536 of a measurement. The driver records the exact cycle index at which each result must appear, together with its data. The monitor compares both the data and the cycle at the falling clock edge, so an early, late or extra result is reported as a failure.

// File: rtl/lsi_pkg.sv
package lsi_pkg;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ARR1 = 2'd1,
    PH_ARR2 = 2'd2
  } meas_phase_e;
endpackage

// File: rtl/lsi_tick_gen.sv
module lsi_tick_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [1:0] range_sel,
  output logic       tick
);
  logic ph_q, ph_d;
  logic fast;

  assign fast = (range_sel >= 2'd2);

  always_comb begin
    ph_d = clr ? 1'b0 : ~ph_q;
    tick = ~clr & (fast | ph_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 1'b0;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/lsi_int_seq.sv
module lsi_int_seq #(
  parameter int CNT_W = lsi_pkg::CNT_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick,
  input  logic [1:0] width,
  output logic       done
);
  localparam int STEP = CNT_W / 4;
  localparam logic [CNT_W:0]   ONE_X = {{CNT_W{1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] INC   = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] last_tick(input logic [1:0] w);
    logic [CNT_W:0] full;
    int sh;
    sh   = CNT_W - STEP * int'(w);
    full = (ONE_X << sh) - ONE_X;
    return full[CNT_W-1:0];
  endfunction

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    done  = tick & (cnt_q == last_tick(width));
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (done) cnt_d = '0;
    else if (tick) cnt_d = cnt_q + INC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lsi_ext_seq.sv
module lsi_ext_seq #(
  parameter int CNT_W = lsi_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic             sync,
  output logic             done,
  output logic [CNT_W-1:0] tmr,
  output logic             sat,
  output logic [1:0]       phase
);
  import lsi_pkg::*;
  localparam logic [CNT_W-1:0] INC = {{(CNT_W-1){1'b0}}, 1'b1};

  meas_phase_e      ph_q, ph_d;
  logic [CNT_W-1:0] tmr_q, tmr_d;
  logic             sat_q, sat_d;

  always_comb begin
    ph_d  = ph_q;
    tmr_d = tmr_q;
    sat_d = sat_q;
    done  = 1'b0;
    if (tick && ph_q != PH_IDLE) begin
      if (&tmr_q) sat_d = 1'b1;
      else        tmr_d = tmr_q + INC;
    end
    if (sync) begin
      unique case (ph_q)
        PH_IDLE: begin
          ph_d  = PH_ARR1;
          tmr_d = '0;
          sat_d = 1'b0;
        end
        PH_ARR1: ph_d = PH_ARR2;
        PH_ARR2: begin
          done  = 1'b1;
          ph_d  = PH_ARR1;
          tmr_d = '0;
          sat_d = 1'b0;
        end
        default: ph_d = PH_IDLE;
      endcase
    end
    if (clr) begin
      ph_d  = PH_IDLE;
      tmr_d = '0;
      sat_d = 1'b0;
      done  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      tmr_q <= '0;
      sat_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      tmr_q <= tmr_d;
      sat_q <= sat_d;
    end
  end

  assign tmr   = tmr_q;
  assign sat   = sat_q;
  assign phase = ph_q;
endmodule

// File: rtl/lsi_timing_ctrl.sv
module lsi_timing_ctrl #(
  parameter int DATA_W = lsi_pkg::DATA_W,
  parameter int CNT_W  = lsi_pkg::CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_enable,
  input  logic              cmd_pdown,
  input  logic              cmd_ext_mode,
  input  logic [1:0]        cmd_width,
  input  logic [1:0]        range_sel,
  input  logic              sync_stb,
  input  logic [DATA_W-1:0] adc_value,
  output logic              result_valid,
  output logic [DATA_W-1:0] sensor_data,
  output logic [CNT_W-1:0]  timer_data,
  output logic              timer_sat,
  output logic [1:0]        arr_phase
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  // configuration tracking for abort on change
  logic [1:0] width_q;
  logic       mode_q;
  logic       run, cfg_chg, clr, tick;

  assign run     = cmd_enable & ~cmd_pdown;
  assign cfg_chg = (cmd_width != width_q) | (cmd_ext_mode != mode_q);
  assign clr     = ~run | cfg_chg;

  lsi_tick_gen u_tick (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .clr       (clr),
    .range_sel (range_sel),
    .tick      (tick)
  );

  logic int_done;
  lsi_int_seq #(.CNT_W(CNT_W)) u_int (
    .clk   (clk),
    .rst_n (rst_s_n),
    .clr   (clr | cmd_ext_mode),
    .tick  (tick),
    .width (cmd_width),
    .done  (int_done)
  );

  logic             ext_done, ext_sat;
  logic [CNT_W-1:0] ext_tmr;
  logic [1:0]       ext_phase;
  lsi_ext_seq #(.CNT_W(CNT_W)) u_ext (
    .clk   (clk),
    .rst_n (rst_s_n),
    .clr   (clr | ~cmd_ext_mode),
    .tick  (tick),
    .sync  (sync_stb),
    .done  (ext_done),
    .tmr   (ext_tmr),
    .sat   (ext_sat),
    .phase (ext_phase)
  );

  // result registers
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] sens_q, sens_d;
  logic [CNT_W-1:0]  tdat_q, tdat_d;

  always_comb begin
    valid_d = int_done | ext_done;
    sens_d  = valid_d ? adc_value : sens_q;
    tdat_d  = tdat_q;
    if (ext_done)      tdat_d = ext_tmr;
    else if (int_done) tdat_d = '0;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      width_q <= 2'b00;
      mode_q  <= 1'b0;
      valid_q <= 1'b0;
      sens_q  <= '0;
      tdat_q  <= '0;
    end else begin
      width_q <= cmd_width;
      mode_q  <= cmd_ext_mode;
      valid_q <= valid_d;
      sens_q  <= sens_d;
      tdat_q  <= tdat_d;
    end
  end

  assign result_valid = valid_q;
  assign sensor_data  = sens_q;
  assign timer_data   = tdat_q;
  assign timer_sat    = ext_sat;
  assign arr_phase    = ext_phase;
endmodule

// File: rtl/lsi_timing_ctrl_chk.sv
module lsi_timing_ctrl_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_enable,
  input logic              cmd_pdown,
  input logic              cmd_ext_mode,
  input logic [1:0]        cmd_width,
  input logic              sync_stb,
  input logic              result_valid,
  input logic [DATA_W-1:0] sensor_data,
  input logic [CNT_W-1:0]  timer_data,
  input logic              timer_sat,
  input logic [1:0]        arr_phase
);
  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  a_r7_off_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_enable || cmd_pdown) |=> !result_valid);

  a_r7_off_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_enable || cmd_pdown) |=> $stable(sensor_data));

  a_r7_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_enable || cmd_pdown) |=> (arr_phase == 2'd0));

  a_r4_int_timer_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ext_mode |=> (!result_valid || timer_data == '0));

  a_r9_int_no_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ext_mode |=> (arr_phase == 2'd0));

  a_r6_sat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_sat && !sync_stb && cmd_enable && !cmd_pdown &&
     $stable(cmd_width) && $stable(cmd_ext_mode)) |=> timer_sat);
endmodule

bind lsi_timing_ctrl lsi_timing_ctrl_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_enable   (cmd_enable),
  .cmd_pdown    (cmd_pdown),
  .cmd_ext_mode (cmd_ext_mode),
  .cmd_width    (cmd_width),
  .sync_stb     (sync_stb),
  .result_valid (result_valid),
  .sensor_data  (sensor_data),
  .timer_data   (timer_data),
  .timer_sat    (timer_sat),
  .arr_phase    (arr_phase)
);

// File: tb/tb_lsi_timing_ctrl.sv
module tb_lsi_timing_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_enable, cmd_pdown, cmd_ext_mode, sync_stb;
  logic [1:0]  cmd_width, range_sel;
  logic [15:0] adc_value;
  logic        result_valid, timer_sat;
  logic [15:0] sensor_data, timer_data;
  logic [1:0]  arr_phase;

  always #10 clk = ~clk;

  lsi_timing_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_enable(cmd_enable), .cmd_pdown(cmd_pdown),
    .cmd_ext_mode(cmd_ext_mode), .cmd_width(cmd_width), .range_sel(range_sel),
    .sync_stb(sync_stb), .adc_value(adc_value), .result_valid(result_valid),
    .sensor_data(sensor_data), .timer_data(timer_data), .timer_sat(timer_sat),
    .arr_phase(arr_phase)
  );

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk  = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  typedef struct {
    logic [15:0] s;
    logic [15:0] t;
    longint      at;
    string       tag;
  } exp_t;
  exp_t sb[$];

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] s, input logic [15:0] t, input longint at, input string tag);
    exp_t e;
    e.s = s; e.t = t; e.at = at; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compares each published result with the next expected item
  always @(negedge clk) begin
    if (rst_n && result_valid) begin
      if (sb.size() == 0) begin
        chk("R2", "unexpected result at cycle", cyc, -1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "result cycle", cyc, e.at);
        chk(e.tag, "sensor_data", longint'(sensor_data), longint'(e.s));
        chk(e.tag, "timer_data", longint'(timer_data), longint'(e.t));
      end
    end
  end

  task automatic step_to(input longint k);
    while (cyc < k) @(negedge clk);
  endtask

  task automatic start(input logic [1:0] w, input logic [1:0] rng, input logic ext, output longint c);
    cmd_enable = 1'b0; cmd_width = w; range_sel = rng; cmd_ext_mode = ext;
    @(negedge clk);
    c = cyc;
    cmd_enable = 1'b1;
  endtask

  task automatic stop();
    cmd_enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic sync_pulse();
    sync_stb = 1'b1;
    @(negedge clk);
    sync_stb = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    longint c, ea, eb, ec, e2, m;
    logic [15:0] s0;
    rst_n = 1'b0; cmd_enable = 1'b0; cmd_pdown = 1'b0; cmd_ext_mode = 1'b0;
    cmd_width = 2'b00; range_sel = 2'b00; sync_stb = 1'b0; adc_value = 16'h0000;
    repeat (4) @(negedge clk);
    chk("R1", "result_valid in reset", result_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "sensor_data", sensor_data, 0);
    chk("R1", "timer_data", timer_data, 0);
    chk("R1", "timer_sat", timer_sat, 0);
    chk("R1", "arr_phase", arr_phase, 0);

    // R2/R4: fast range, 16 ticks, two back-to-back conversions
    adc_value = 16'h1234;
    start(2'b11, 2'b11, 1'b0, c);
    push(16'h1234, 16'h0000, c + 16, "R2");
    push(16'h1234, 16'h0000, c + 32, "R4");
    step_to(c + 33);
    stop();

    // R3: slow range halves the tick rate; negative result
    adc_value = 16'h8001;
    start(2'b11, 2'b01, 1'b0, c);
    push(16'h8001, 16'h0000, c + 32, "R3");
    step_to(c + 32);
    stop();

    // R2: other widths
    adc_value = 16'h00A5;
    start(2'b10, 2'b10, 1'b0, c);
    push(16'h00A5, 16'h0000, c + 256, "R2");
    step_to(c + 256);
    stop();
    adc_value = 16'h7FFF;
    start(2'b01, 2'b00, 1'b0, c);
    push(16'h7FFF, 16'h0000, c + 8192, "R3");
    step_to(c + 8192);
    stop();
    adc_value = 16'hFFFE;
    start(2'b00, 2'b11, 1'b0, c);
    push(16'hFFFE, 16'h0000, c + 65536, "R2");
    step_to(c + 65536);
    stop();

    // R8: width change mid-count restarts from zero
    adc_value = 16'h0C0C;
    start(2'b11, 2'b11, 1'b0, c);
    step_to(c + 10);
    cmd_width = 2'b10;
    push(16'h0C0C, 16'h0000, c + 267, "R8");
    step_to(c + 267);
    stop();

    // R7: power-down halts, holds data, restarts from zero
    start(2'b11, 2'b11, 1'b0, c);
    step_to(c + 8);
    cmd_pdown = 1'b1;
    s0 = sensor_data;
    adc_value = 16'h5A5A;
    step_to(c + 11);
    chk("R7", "sensor_data held while off", sensor_data, s0);
    cmd_pdown = 1'b0;
    push(16'h5A5A, 16'h0000, c + 27, "R7");
    step_to(c + 27);
    stop();

    // R9: sync in internal mode ignored
    adc_value = 16'h0909;
    start(2'b11, 2'b11, 1'b0, c);
    step_to(c + 3);
    sync_pulse();
    chk("R9", "arr_phase after sync", arr_phase, 0);
    push(16'h0909, 16'h0000, c + 16, "R9");
    step_to(c + 16);
    stop();

    // R7: sync ignored while disabled in external mode
    cmd_ext_mode = 1'b1;
    @(negedge clk);
    sync_pulse();
    chk("R7", "arr_phase sync while off", arr_phase, 0);

    // R5: external three-strobe sequence
    start(2'b11, 2'b11, 1'b1, c);
    step_to(c + 5);
    chk("R5", "arr_phase before sync", arr_phase, 0);
    sync_pulse();
    ea = cyc;
    chk("R5", "arr_phase after 1st sync", arr_phase, 1);
    step_to(ea + 20);
    sync_pulse();
    eb = cyc;
    chk("R5", "arr_phase after 2nd sync", arr_phase, 2);
    step_to(eb + 30);
    adc_value = 16'h3C3C;
    push(16'h3C3C, 16'd51, eb + 31, "R5");
    sync_pulse();
    ec = cyc;
    chk("R5", "arr_phase after 3rd sync", arr_phase, 1);
    step_to(ec + 9);
    sync_pulse();
    e2 = cyc;
    chk("R5", "arr_phase second measurement", arr_phase, 2);
    step_to(e2 + 4);
    adc_value = 16'hC3C3;
    push(16'hC3C3, 16'd14, e2 + 5, "R5");
    sync_pulse();

    // R8: mode change aborts external measurement, internal restarts
    m = cyc;
    cmd_ext_mode = 1'b0;
    push(16'hC3C3, 16'h0000, m + 17, "R8");
    @(negedge clk);
    chk("R8", "arr_phase after mode change", arr_phase, 0);
    step_to(m + 17);
    stop();

    // R6: external timer saturation
    adc_value = 16'h4242;
    start(2'b11, 2'b11, 1'b1, c);
    step_to(c + 2);
    sync_pulse();
    ea = cyc;
    step_to(ea + 65535);
    chk("R6", "timer_sat at ceiling", timer_sat, 0);
    @(negedge clk);
    chk("R6", "timer_sat one tick later", timer_sat, 1);
    step_to(ea + 65540);
    sync_pulse();
    eb = cyc;
    step_to(eb + 2);
    push(16'h4242, 16'hFFFF, eb + 3, "R6");
    sync_pulse();
    chk("R6", "timer_sat cleared on new measurement", timer_sat, 0);
    stop();

    repeat (5) @(negedge clk);
    chk("R2", "pending expected results", sb.size(), 0);
    done_flag = 1'b1;
    summary();
    $finish;
  end
endmodule